// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns burst commands for a four-bank, 16-bit synchronous DRAM into a per-cycle stream of bank and column addresses. Each beat is flagged either as a write beat, where write data is accepted, or as a read beat. Read beats also raise a read-data-valid strobe a programmable number of clocks after the command. A controller places the block between its command arbiter and the DRAM pin logic. It presents one command per cycle together with the mode settings, and it uses the beat outputs to drive column commands and to steer the data path.

Four ordering rules apply: sequential wrap inside an aligned block of 1, 2, 4 or 8 beats, interleaved ordering, an endless full-page sweep, and a mode that makes writes single-beat while reads keep the programmed length. A stop command cuts any burst short. A new read or write cuts it over with no idle cycle. Read beats that were already issued still produce their valid strobes at the original latency.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted and after it is released, with only NOP commands, `beat_act`, `wr_accept` and `rd_valid` are low.
- R2: Command codes are NOP=0, READ=1, WRITE=2, STOP=3. A READ or WRITE sampled on a clock edge produces beat 0 in the next cycle with the command's bank and start column. Later beats follow on consecutive cycles. The number of beats follows `cfg_bl`: 0→1, 1→2, 2→4, 3→8, and 4 to 7→full page.
- R3: With `cfg_ilv`=0, beat k has column bits above log2(len) equal to the start column. Its low log2(len) bits are (start + k) mod len.
- R4: With `cfg_ilv`=1, beat k has low log2(len) bits equal to start XOR k, and the upper bits equal to the start column.
- R5: A full-page sequential burst steps through the columns modulo 512 and never ends by itself.
- R6: A READ or WRITE issued while `cfg_ilv`=1 and `cfg_bl`≥4 is rejected. It starts nothing and leaves any burst in progress running unchanged.
- R7: `rd_valid` pulses once for every read beat. With `cfg_cl3`=0 the pulse comes 2 clock edges after that beat's column command is sampled, which for beat 0 is 2 edges after the READ. With `cfg_cl3`=1 the delay is 3 edges.
- R8: A STOP sampled on an edge ends the burst: no beat appears in the following cycle.
- R9: A READ or WRITE that arrives during a burst replaces it. Its own beat 0 appears in the next cycle with no idle cycle in between.
- R10: Read beats issued before an interruption or a stop still produce their `rd_valid` pulses at their original latency.
- R11: With `cfg_wsingle`=1, a WRITE produces exactly one beat whatever `cfg_bl` is, while a READ uses the full programmed length.
- R12: `wr_accept` is high exactly in write-beat cycles. In those cycles `mask_out` equals `mask_in`; in all other cycles it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op | input | 2 | Command: 0 NOP, 1 READ, 2 WRITE, 3 STOP |
| cmd_bank | input | 2 | Bank of the burst command |
| cmd_col | input | 9 | Starting column |
| cfg_bl | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| cfg_ilv | input | 1 | 1 selects interleaved ordering |
| cfg_cl3 | input | 1 | Read latency: 0 gives 2 clocks, 1 gives 3 clocks |
| cfg_wsingle | input | 1 | 1 makes writes single-beat |
| mask_in | input | 2 | Upper/lower byte mask for the current write beat |
| beat_act | output | 1 | A burst beat is presented this cycle |
| beat_bank | output | 2 | Bank of the current beat |
| beat_col | output | 9 | Column of the current beat |
| wr_accept | output | 1 | Current beat is a write beat; write data is taken |
| rd_valid | output | 1 | Read data for an earlier read beat is valid |
| mask_out | output | 2 | Byte mask for the current write beat, 0 otherwise |

## Verification
A wrong beat counter or a wrong latched length mask shows up at `beat_col` on the very next beat. At the latest it shows in the cycle where the burst should end, as an extra or a missing `beat_act`. A corrupted latency pipeline or a pipeline wrongly flushed on interruption only shows 2 to 3 cycles later, as a missing, doubled or shifted `rd_valid`. The scoreboard therefore tracks read-valid cycles separately from beats. A mis-handled reject or write-single decision shows in the first cycle after the command, because the expected beat stream changes there.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } seq_op_e;

  // smallest burst-length code that means "full page"
  localparam int unsigned BL_FULL_CODE = 4;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/seq_burst_ctrl.sv
module seq_burst_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int BL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_op_e           op_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BL_W-1:0]   bl_i,
  input  logic              ilv_i,
  input  logic              wsingle_i,
  output logic              act_o,
  output logic              wr_o,
  output logic              ilv_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  start_o,
  output logic [COL_W-1:0]  cnt_o,
  output logic [COL_W-1:0]  mask_o
);

  logic              act_q, act_d;
  logic [COL_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, full_q, ilv_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  start_q, mask_q;

  logic              full_code, illegal, is_rw, accept, one_beat, last_beat;
  logic [COL_W-1:0]  code_mask;

  // decode of the length code into a low-bit mask
  always_comb begin
    full_code = (int'(bl_i) >= int'(BL_FULL_CODE));
    for (int i = 0; i < COL_W; i++) begin
      code_mask[i] = full_code || (i < int'(bl_i));
    end
  end

  assign is_rw     = (op_i == OP_READ) || (op_i == OP_WRITE);
  assign illegal   = ilv_i && full_code;
  assign accept    = is_rw && !illegal;
  assign one_beat  = (op_i == OP_WRITE) && wsingle_i;
  assign last_beat = !full_q && (cnt_q == mask_q);

  // next state
  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (accept) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (op_i == OP_STOP) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (last_beat) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  // burst attributes, loaded only on an accepted command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      wr_q    <= (op_i == OP_WRITE);
      full_q  <= full_code && !one_beat;
      ilv_q   <= ilv_i;
      bank_q  <= bank_i;
      start_q <= col_i;
      mask_q  <= one_beat ? '0 : code_mask;
    end
  end

  assign act_o   = act_q;
  assign wr_o    = wr_q;
  assign ilv_o   = ilv_q;
  assign bank_o  = bank_q;
  assign start_o = start_q;
  assign cnt_o   = cnt_q;
  assign mask_o  = mask_q;

  // R8: a stop leaves no beat in the next cycle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STOP) |=> !act_q);

  // R9: a legal command restarts at beat 0 with its own bank and column
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (act_q && cnt_q == '0 && bank_q == $past(bank_i) && start_q == $past(col_i)));

  // R6: a rejected command does not disturb the burst in flight
  a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && illegal) |=> ($stable(bank_q) && $stable(start_q) && $stable(mask_q)));

  // R11: a single-beat write followed by NOP is over after one beat
  a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_WRITE) && wsingle_i && !illegal) ##1 (op_i == OP_NOP) |=> !act_q);

  // R2: a bounded burst never runs past its length
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> (cnt_q <= mask_q));

endmodule

// File: rtl/seq_col_gen.sv
module seq_col_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = start_i + cnt_i;

  // bits outside the burst window come from the start column; inside it
  // they either count (sequential) or flip with the beat index (interleaved)
  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    assign col_o[g] = !mask_i[g] ? start_i[g]
                    : (ilv_i ? (start_i[g] ^ cnt_i[g]) : sum[g]);
  end
endmodule

// File: rtl/seq_rd_pipe.sv
module seq_rd_pipe #(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic lat_sel_i,
  output logic vld_o
);
  localparam int DEPTH = MAX_LAT - MIN_LAT + 1;

  logic [DEPTH-1:0] pipe_q, pipe_d;

  // stage 0 already sits one edge behind the beat, which is itself one
  // edge behind the command: tap k gives latency MIN_LAT + k
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign pipe_d[g] = issue_i;
    end else begin : g_tail
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign vld_o = pipe_q[lat_sel_i];

  // R7: latency 2 after a read beat
  a_r7_lat_short: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_i) && !lat_sel_i) |-> vld_o);

  // R7: latency 3 after a read beat
  a_r7_lat_long: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_i, 2) && lat_sel_i) |-> vld_o);

  // R10: no valid strobe without a read beat behind it
  a_r10_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ($past(issue_i) || $past(issue_i, 2)));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int COL_W   = 9,
  parameter int BL_W    = 3,
  parameter int MASK_W  = 2,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BL_W-1:0]   cfg_bl,
  input  logic              cfg_ilv,
  input  logic              cfg_cl3,
  input  logic              cfg_wsingle,
  input  logic [MASK_W-1:0] mask_in,
  output logic              beat_act,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              wr_accept,
  output logic              rd_valid,
  output logic [MASK_W-1:0] mask_out
);

  logic             srst_n;
  logic             act, wr, ilv;
  logic [COL_W-1:0] start, cnt, lmask;

  seq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seq_burst_ctrl #(
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .BL_W   (BL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .op_i      (seq_op_e'(cmd_op)),
    .bank_i    (cmd_bank),
    .col_i     (cmd_col),
    .bl_i      (cfg_bl),
    .ilv_i     (cfg_ilv),
    .wsingle_i (cfg_wsingle),
    .act_o     (act),
    .wr_o      (wr),
    .ilv_o     (ilv),
    .bank_o    (beat_bank),
    .start_o   (start),
    .cnt_o     (cnt),
    .mask_o    (lmask)
  );

  seq_col_gen #(.COL_W(COL_W)) u_col (
    .start_i (start),
    .cnt_i   (cnt),
    .mask_i  (lmask),
    .ilv_i   (ilv),
    .col_o   (beat_col)
  );

  seq_rd_pipe #(
    .MIN_LAT (MIN_LAT),
    .MAX_LAT (MAX_LAT)
  ) u_rd (
    .clk       (clk),
    .rst_n     (srst_n),
    .issue_i   (act && !wr),
    .lat_sel_i (cfg_cl3),
    .vld_o     (rd_valid)
  );

  assign beat_act  = act;
  assign wr_accept = act && wr;
  assign mask_out  = wr_accept ? mask_in : '0;

endmodule

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb;

  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, STP = 2'd3;

  logic       clk, rst_n;
  logic [1:0] cmd_op, cmd_bank, mask_in;
  logic [8:0] cmd_col;
  logic [2:0] cfg_bl;
  logic       cfg_ilv, cfg_cl3, cfg_wsingle;
  logic       beat_act, wr_accept, rd_valid;
  logic [1:0] beat_bank, mask_out;
  logic [8:0] beat_col;

  sdram_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .cfg_cl3(cfg_cl3),
    .cfg_wsingle(cfg_wsingle), .mask_in(mask_in), .beat_act(beat_act),
    .beat_bank(beat_bank), .beat_col(beat_col), .wr_accept(wr_accept),
    .rd_valid(rd_valid), .mask_out(mask_out)
  );

  typedef struct { int cyc; logic [1:0] bank; logic [8:0] col; bit wr; } beat_t;
  beat_t bq[$];
  int    rdq[$];
  int    cyc = 0;
  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) mask_in <= 2'($urandom);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(input logic [8:0] s, input int k, input int len, input bit ilv);
    logic [8:0] m = 9'(len - 1);
    logic [8:0] kk = 9'(k);
    return ilv ? ((s & ~m) | ((s ^ kk) & m)) : ((s & ~m) | ((s + kk) & m));
  endfunction

  // driver: one command, then NOPs until the next command slot gap cycles later
  task automatic send(input logic [1:0] op, input logic [1:0] bk, input logic [8:0] col,
                      input int gap, input bit cut);
    int n, len, nb;
    bit full, legal;
    @(negedge clk);
    n = cyc;
    cmd_op = op; cmd_bank = bk; cmd_col = col;
    full  = (cfg_bl >= 3'd4);
    legal = (op == RD || op == WR) && !(cfg_ilv && full);
    if (legal) begin
      len = full ? 512 : (1 << cfg_bl);
      if (op == WR && cfg_wsingle) begin len = 1; full = 0; end
      nb = full ? gap : ((cut && gap < len) ? gap : len);
      for (int k = 0; k < nb; k++) begin
        beat_t b;
        b.cyc = n + 1 + k; b.bank = bk; b.col = exp_col(col, k, len, cfg_ilv); b.wr = (op == WR);
        bq.push_back(b);
        if (op == RD) rdq.push_back(n + 1 + k + (cfg_cl3 ? 2 : 1));
      end
    end
    for (int i = 1; i < gap; i++) begin
      @(negedge clk);
      cmd_op = NOP;
    end
  endtask

  task automatic idle(input int n);
    send(NOP, 2'd0, 9'd0, n, 1'b1);
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #1;
    if (!done) begin
      bit    eb, er, ewr;
      beat_t b;
      eb  = (bq.size() > 0) && (bq[0].cyc == cyc);
      ewr = 1'b0;
      chk(beat_act == eb, tag, "beat_act", beat_act, eb);
      if (eb) begin
        b = bq.pop_front();
        ewr = b.wr;
        if (beat_act) begin
          chk(beat_bank == b.bank, tag, "beat_bank", beat_bank, b.bank);
          chk(beat_col == b.col, tag, "beat_col", beat_col, b.col);
        end
      end
      chk(wr_accept == ewr, tag, "wr_accept (R12)", wr_accept, ewr);
      chk(mask_out == (ewr ? mask_in : 2'b00), tag, "mask_out (R12)", mask_out, ewr ? mask_in : 2'b00);
      er = (rdq.size() > 0) && (rdq[0] == cyc);
      if (er) void'(rdq.pop_front());
      chk(rd_valid == er, tag, "rd_valid", rd_valid, er);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_op = NOP; cmd_bank = 0; cmd_col = 0;
    cfg_bl = 3'd2; cfg_ilv = 0; cfg_cl3 = 0; cfg_wsingle = 0;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);

    // R3: sequential wrap within a 4-beat block
    tag = "R3";
    send(RD, 2'd2, 9'h0A6, 6, 1);
    // R12: write burst of 8 with random masks
    tag = "R12"; cfg_bl = 3'd3;
    send(WR, 2'd1, 9'h105, 10, 1);
    // R4 / R7: interleaved reads at latency 3
    idle(4);
    tag = "R4"; cfg_ilv = 1; cfg_cl3 = 1;
    send(RD, 2'd3, 9'h0B5, 10, 1);
    tag = "R7"; cfg_bl = 3'd2;
    send(RD, 2'd0, 9'h0F2, 6, 1);
    idle(4);
    // R2: short bursts, latency 2
    tag = "R2"; cfg_ilv = 0; cfg_cl3 = 0; cfg_bl = 3'd0;
    send(RD, 2'd1, 9'h033, 3, 1);
    cfg_bl = 3'd1;
    send(RD, 2'd1, 9'h033, 4, 1);
    send(WR, 2'd0, 9'h1FF, 3, 1);
    // R5 / R8: full page wraps past 511, then stop
    tag = "R5"; cfg_bl = 3'd7;
    send(RD, 2'd2, 9'h1FD, 6, 1);
    tag = "R8";
    send(STP, 2'd0, 9'd0, 5, 1);
    // R9: interruption with no idle cycle
    tag = "R9"; cfg_bl = 3'd3;
    send(RD, 2'd0, 9'h010, 3, 1);
    send(WR, 2'd3, 9'h1C4, 1, 1);
    send(RD, 2'd1, 9'h07E, 8, 1);
    idle(4);
    // R10: stop mid read at latency 3, issued beats still drain
    tag = "R10"; cfg_cl3 = 1;
    send(RD, 2'd2, 9'h140, 2, 1);
    send(STP, 2'd0, 9'd0, 6, 1);
    idle(4);
    // R6: illegal interleave + full page is rejected, idle and busy
    tag = "R6"; cfg_cl3 = 0; cfg_ilv = 1; cfg_bl = 3'd4;
    send(RD, 2'd0, 9'h020, 4, 1);
    cfg_ilv = 0; cfg_bl = 3'd3;
    send(RD, 2'd1, 9'h088, 3, 0);
    cfg_ilv = 1; cfg_bl = 3'd5;
    send(WR, 2'd2, 9'h000, 8, 1);
    // R11: single-beat writes, reads keep their length
    tag = "R11"; cfg_ilv = 0; cfg_wsingle = 1; cfg_bl = 3'd3;
    send(WR, 2'd3, 9'h0C3, 4, 1);
    cfg_bl = 3'd2;
    send(RD, 2'd3, 9'h0C3, 6, 1);
    idle(10);

    tag = "R10";
    chk(bq.size() == 0, "R2", "leftover beats", bq.size(), 0);
    chk(rdq.size() == 0, "R10", "leftover read valids", rdq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule